// File: doc/BRIEF.md
# DS3 Idle Signal Detector

This block watches the bit stream of a DS3 receive path after a framer has found alignment, and reports whether the far end is sending the idle signal. The framer tells it, bit by bit, whether each bit is payload or overhead. For overhead bits it also gives the bit's kind and its subframe number. A strobe marks the bit that closes each M-frame.

Every M-frame gets a single verdict: qualifying or not. A frame qualifies when three things all hold for that frame:
- the C bits of subframe 3 are all zero;
- both X bits are one;
- the payload follows the repeating 1100 sequence in the right phase.

A run of 63 qualifying frames in a row declares idle. A run of 63 non-qualifying frames in a row clears it. Any frame that agrees with the current status restarts the run. When the framer reports loss of framing, the run counter and the frame being gathered are discarded.

The result is an idle status level and a one-cycle pulse whenever that level changes. The pulse is meant for an alarm or interrupt collector.

Top module: `ds3idl_det`

## Requirements
- R1: A frame qualifies only if exactly three C overhead bits of subframe 3 are seen, and all three are 0. Overhead kind code 4 means C, and `sf_num` counts subframes from 1 to 7.
- R2: A frame qualifies only if exactly two X overhead bits (kind code 0) are seen, and both are 1.
- R3: Each payload bit of a frame must equal 1,1,0,0,1,1,0,0,… in order. The sequence index advances only on payload strobes. It does not move on overhead bits or empty cycles. It restarts at the first payload bit after an M-frame end strobe, so a frame that starts one step late does not qualify.
- R4: `idle` rises after the 63rd qualifying frame in a row. The change appears in the second clock cycle after the `mf_end` strobe of that frame, and not one frame earlier.
- R5: `idle` falls after the 63rd non-qualifying frame in a row, with the same timing as R4, and not one frame earlier.
- R6: The values of P (code 1), M (code 2) and F (code 3) bits have no effect on the verdict. Neither do C bits outside subframe 3.
- R7: A frame whose verdict agrees with the current `idle` level restarts the persistence run from zero.
- R8: While `lof` is high, all strobes are ignored. The persistence count and the partly gathered frame are cleared, and `idle` keeps its value.
- R9: `idle_chg` is high for exactly one cycle, in the cycle in which `idle` takes its new value, and is low at all other times. After reset, `idle` and `idle_chg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lof | input | 1 | Loss of framing from the framer; clears the detector |
| din | input | 1 | Received bit |
| pay_stb | input | 1 | `din` is a payload bit |
| oh_stb | input | 1 | `din` is an overhead bit |
| oh_kind | input | 3 | Overhead kind: 0 X, 1 P, 2 M, 3 F, 4 C |
| sf_num | input | 3 | Subframe number 1 to 7 of the overhead bit |
| mf_end | input | 1 | This cycle's bit (if any) closes the M-frame |
| idle | output | 1 | Idle signal declared |
| idle_chg | output | 1 | One-cycle pulse when `idle` changes |

## Verification
The stimulus is built from frames of several kinds:
- clean idle frames;
- idle frames with random P, M, F and other-subframe C bits;
- frames with one C bit of subframe 3 set;
- frames with an X bit cleared;
- frames with a single flipped payload bit;
- frames whose 1100 sequence starts one step late;
- frames missing a subframe-3 C bit.

Empty cycles are spread through the stream so that the sequence phase has to be carried across overhead bits and gaps. While the idle level is set, the clearing run interleaves every bad kind. If the design wrongly accepted any one of them, the run would restart and the clear would be missed at frame 63. A single bad frame inside a good run tells the R7 restart apart from a counter that only accumulates. Loss of framing is applied both between frames and in the middle of a frame carrying a bad C bit. This separates a proper discard of the partial frame from one that leaks into the next frame's verdict.

// File: rtl/ds3idl_pkg.sv
package ds3idl_pkg;

  // Overhead bit kinds as reported by the framer
  typedef enum logic [2:0] {
    OH_X = 3'd0,
    OH_P = 3'd1,
    OH_M = 3'd2,
    OH_F = 3'd3,
    OH_C = 3'd4
  } oh_kind_e;

  localparam int unsigned IDL_PERSIST  = 63;      // frames to declare or clear
  localparam int unsigned IDL_PAT_LEN  = 4;       // payload sequence length
  localparam logic [3:0]  IDL_PATTERN  = 4'b0011; // bit i = expected value at index i
  localparam int unsigned IDL_C_SF     = 3;       // subframe holding the checked C bits
  localparam int unsigned IDL_NUM_C    = 3;
  localparam int unsigned IDL_NUM_X    = 2;

endpackage

// File: rtl/ds3idl_pat_chk.sv
// Payload sequence checker: tracks the index of the repeating idle pattern
// across overhead bits and gaps, and keeps a sticky mismatch flag per frame.
module ds3idl_pat_chk #(
  parameter int unsigned          PAT_LEN = 4,
  parameter logic [PAT_LEN-1:0]   PATTERN = 4'b0011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pay_stb,
  input  logic din,
  input  logic restart,
  output logic frame_ok
);
  localparam int unsigned PH_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PAT_LEN - 1);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            mis_q, mis_d;
  logic            bit_bad;
  logic            ph_en;

  always_comb begin
    bit_bad = pay_stb && (din != PATTERN[ph_q]);
    ph_en   = clr || restart || pay_stb;
    ph_d    = ph_q;
    if (clr || restart) begin
      ph_d = '0;
    end else if (pay_stb) begin
      ph_d = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    end
    if (clr || restart) begin
      mis_d = 1'b0;
    end else begin
      mis_d = mis_q | bit_bad;
    end
    frame_ok = !(mis_q || bit_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      mis_q <= 1'b0;
    end else begin
      if (ph_en) begin
        ph_q <= ph_d;
      end
      mis_q <= mis_d;
    end
  end

  AST_PH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ph_q == '0)); // R3
  AST_PH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pay_stb && !restart && !clr) |=> $stable(ph_q)); // R3
  AST_MIS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_q && !restart && !clr) |=> mis_q); // R3

endmodule

// File: rtl/ds3idl_slot_cnt.sv
// Counts one class of overhead slot within a frame and records whether any
// occurrence carried the spoiling value. ok_now includes the current bit.
module ds3idl_slot_cnt #(
  parameter int unsigned NEED    = 3,
  parameter logic        BAD_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit,
  input  logic din,
  input  logic restart,
  output logic ok_now
);
  localparam int unsigned CMAX = NEED + 1;
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(CMAX);
  localparam logic [CW-1:0] CNT_NEED = CW'(NEED);

  logic [CW-1:0] cnt_q, cnt_d, cnt_now;
  logic          bad_q, bad_d, bad_now;

  always_comb begin
    cnt_now = cnt_q;
    if (hit && (cnt_q != CNT_SAT)) begin
      cnt_now = cnt_q + 1'b1;
    end
    bad_now = bad_q || (hit && (din == BAD_VAL));
    if (clr || restart) begin
      cnt_d = '0;
      bad_d = 1'b0;
    end else begin
      cnt_d = cnt_now;
      bad_d = bad_now;
    end
    ok_now = (cnt_now == CNT_NEED) && !bad_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      bad_q <= bad_d;
    end
  end

  AST_SLOT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_SAT); // R1
  AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (restart || clr) |=> (cnt_q == '0) && !bad_q); // R2
  AST_SLOT_BADKEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_q && !restart && !clr) |=> bad_q); // R1

endmodule

// File: rtl/ds3idl_persist.sv
// Persistence integrator: flips the idle status after PERSIST consecutive
// frame verdicts that disagree with it; an agreeing verdict restarts the run.
module ds3idl_persist #(
  parameter int unsigned PERSIST = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic vld,
  input  logic verd,
  output logic idle,
  output logic idle_chg
);
  localparam int unsigned CNT_W = (PERSIST > 1) ? $clog2(PERSIST) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERSIST - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             idle_q, idle_d;
  logic             chg_q, chg_d;

  always_comb begin
    cnt_d  = cnt_q;
    idle_d = idle_q;
    chg_d  = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (vld) begin
      if (verd != idle_q) begin
        if (cnt_q == CNT_LAST) begin
          cnt_d  = '0;
          idle_d = !idle_q;
          chg_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idle_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      idle_q <= idle_d;
      chg_q  <= chg_d;
    end
  end

  assign idle     = idle_q;
  assign idle_chg = chg_q;

  AST_RISE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_q) |-> ($past(cnt_q) == CNT_LAST)); // R4
  AST_FALL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_q) |-> ($past(cnt_q) == CNT_LAST)); // R5
  AST_AGREE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && (verd == idle_q) && !clr) |=> (cnt_q == '0)); // R7
  AST_LOF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && $stable(idle_q)); // R8
  AST_CHG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (idle_q != $past(idle_q))); // R9
  AST_NOCHG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_q |-> $stable(idle_q)); // R9

endmodule

// File: rtl/ds3idl_det.sv
module ds3idl_det
  import ds3idl_pkg::*;
#(
  parameter int unsigned PERSIST = IDL_PERSIST,
  parameter int unsigned PAT_LEN = IDL_PAT_LEN,
  parameter logic [PAT_LEN-1:0] PATTERN = IDL_PATTERN,
  parameter int unsigned C_SF    = IDL_C_SF,
  parameter int unsigned NUM_C   = IDL_NUM_C,
  parameter int unsigned NUM_X   = IDL_NUM_X
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lof,
  input  logic       din,
  input  logic       pay_stb,
  input  logic       oh_stb,
  input  logic [2:0] oh_kind,
  input  logic [2:0] sf_num,
  input  logic       mf_end,
  output logic       idle,
  output logic       idle_chg
);
  localparam logic [2:0] C_SF_CODE = 3'(C_SF);

  // Asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_s = rst_pipe[1];

  // Qualified strobes: nothing counts while framing is lost
  logic pay_q_stb, c_hit, x_hit, end_stb;
  always_comb begin
    pay_q_stb = pay_stb && !lof;
    c_hit     = oh_stb && !lof && (oh_kind == OH_C) && (sf_num == C_SF_CODE);
    x_hit     = oh_stb && !lof && (oh_kind == OH_X);
    end_stb   = mf_end && !lof;
  end

  logic pat_ok, c_ok, x_ok;

  ds3idl_pat_chk #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_pat (
    .clk(clk), .rst_n(rst_s), .clr(lof), .pay_stb(pay_q_stb), .din(din),
    .restart(end_stb), .frame_ok(pat_ok)
  );

  ds3idl_slot_cnt #(.NEED(NUM_C), .BAD_VAL(1'b1)) u_cslot (
    .clk(clk), .rst_n(rst_s), .clr(lof), .hit(c_hit), .din(din),
    .restart(end_stb), .ok_now(c_ok)
  );

  ds3idl_slot_cnt #(.NEED(NUM_X), .BAD_VAL(1'b0)) u_xslot (
    .clk(clk), .rst_n(rst_s), .clr(lof), .hit(x_hit), .din(din),
    .restart(end_stb), .ok_now(x_ok)
  );

  // Frame verdict register
  logic verd_vld_q, verd_vld_d;
  logic verd_q, verd_d, verd_en;

  always_comb begin
    verd_vld_d = end_stb;
    verd_en    = end_stb;
    verd_d     = pat_ok && c_ok && x_ok;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      verd_vld_q <= 1'b0;
      verd_q     <= 1'b0;
    end else begin
      verd_vld_q <= verd_vld_d;
      if (verd_en) begin
        verd_q <= verd_d;
      end
    end
  end

  ds3idl_persist #(.PERSIST(PERSIST)) u_pers (
    .clk(clk), .rst_n(rst_s), .clr(lof), .vld(verd_vld_q), .verd(verd_q),
    .idle(idle), .idle_chg(idle_chg)
  );

  AST_LOF_NOVERD: assert property (@(posedge clk) disable iff (!rst_s)
    lof |=> !verd_vld_q); // R8
  AST_VERD_AFTER_END: assert property (@(posedge clk) disable iff (!rst_s)
    verd_vld_q |-> $past(mf_end)); // R4

endmodule

// File: tb/sim_ds3idl_det.sv
`timescale 1ns/100ps
module sim_ds3idl_det;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lof = 1'b0;
  logic       din = 1'b0;
  logic       pay_stb = 1'b0;
  logic       oh_stb = 1'b0;
  logic [2:0] oh_kind = 3'd0;
  logic [2:0] sf_num = 3'd0;
  logic       mf_end = 1'b0;
  logic       idle, idle_chg;

  always #2.5 clk = ~clk;

  ds3idl_det u0 (
    .clk(clk), .rst_n(rst_n), .lof(lof), .din(din), .pay_stb(pay_stb),
    .oh_stb(oh_stb), .oh_kind(oh_kind), .sf_num(sf_num), .mf_end(mf_end),
    .idle(idle), .idle_chg(idle_chg)
  );

  localparam int K_GOOD = 0, K_BADC = 1, K_BADX = 2, K_BADPAY = 3,
                 K_SHIFT = 4, K_MISSC = 5, K_NOISY = 6;

  int  n_run = 0;
  int  n_fail = 0;
  int  gap_cnt = 0;
  bit  done = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic quiet_cyc();
    @(negedge clk);
    pay_stb = 1'b0; oh_stb = 1'b0; mf_end = 1'b0;
  endtask

  task automatic emit(input bit is_oh, input logic [2:0] kind, input logic [2:0] sf,
                      input logic d, input bit last);
    gap_cnt++;
    if (gap_cnt % 7 == 0) quiet_cyc();
    @(negedge clk);
    pay_stb = !is_oh; oh_stb = is_oh; oh_kind = kind; sf_num = sf;
    din = d; mf_end = last;
  endtask

  function automatic logic pat_bit(input int ph);
    return ((ph % 4) < 2) ? 1'b1 : 1'b0;
  endfunction

  // Send subframes 1..nsf of one M-frame; mf_end only when all 7 are sent.
  task automatic send_frame(input int k, input int nsf);
    int  ph;
    bit  noisy;
    ph    = (k == K_SHIFT) ? 1 : 0;
    noisy = (k == K_NOISY);
    for (int s = 1; s <= nsf; s++) begin
      for (int blk = 0; blk < 8; blk++) begin
        logic [2:0] kd;
        logic       v;
        if (blk == 0) begin
          if (s <= 2) begin
            kd = 3'd0; v = !(k == K_BADX && s == 2);
          end else begin
            kd = (s <= 4) ? 3'd1 : 3'd2;
            v  = noisy ? 1'($urandom % 2) : 1'b0;
          end
        end else if (blk % 2 == 1) begin
          kd = 3'd3; v = noisy ? 1'($urandom % 2) : 1'(blk / 2);
        end else begin
          if (s == 3) begin
            kd = (k == K_MISSC && blk == 6) ? 3'd3 : 3'd4;
            v  = (k == K_BADC && blk == 4);
          end else begin
            kd = 3'd4; v = noisy ? 1'($urandom % 2) : 1'b1;
          end
        end
        emit(1'b1, kd, 3'(s), v, 1'b0);
        for (int j = 0; j < 3; j++) begin
          logic d;
          d = pat_bit(ph);
          if (k == K_BADPAY && s == 5 && blk == 3 && j == 0) d = !d;
          ph++;
          emit(1'b0, 3'd0, 3'(s), d, (nsf == 7 && s == 7 && blk == 7 && j == 2));
        end
      end
    end
    quiet_cyc();
    quiet_cyc();
  endtask

  task automatic pulse_lof();
    @(negedge clk);
    lof = 1'b1; pay_stb = 1'b1; mf_end = 1'b1; din = 1'b0;
    @(negedge clk);
    oh_stb = 1'b1; oh_kind = 3'd4; sf_num = 3'd3; din = 1'b1;
    @(negedge clk);
    lof = 1'b0; pay_stb = 1'b0; oh_stb = 1'b0; mf_end = 1'b0;
    quiet_cyc();
  endtask

  task automatic t_reset();
    chk("R9", "idle after reset", int'(idle), 0);
    chk("R9", "chg after reset", int'(idle_chg), 0);
  endtask

  task automatic t_declare();
    for (int i = 0; i < 62; i++) send_frame(K_GOOD, 7);
    chk("R4", "idle after 62 good", int'(idle), 0);
    chk("R9", "no chg after 62 good", int'(idle_chg), 0);
    send_frame(K_GOOD, 7);
    chk("R4", "idle after 63 good", int'(idle), 1);
    chk("R9", "chg at declare", int'(idle_chg), 1);
    @(negedge clk);
    chk("R9", "chg one cycle", int'(idle_chg), 0);
  endtask

  task automatic t_clear_chain();
    for (int i = 0; i < 62; i++) send_frame(1 + (i % 5), 7);
    chk("R5", "idle after 62 bad", int'(idle), 1);
    send_frame(K_BADPAY, 7);
    chk("R1 R2 R3 R5", "idle after 63 mixed bad", int'(idle), 0);
    chk("R9", "chg at clear", int'(idle_chg), 1);
  endtask

  task automatic t_restart();
    for (int i = 0; i < 30; i++) send_frame(K_NOISY, 7);
    send_frame(K_BADC, 7);
    for (int i = 0; i < 62; i++) send_frame(K_NOISY, 7);
    chk("R7", "idle after restart + 62", int'(idle), 0);
    send_frame(K_NOISY, 7);
    chk("R6", "noisy overhead frames declare", int'(idle), 1);
  endtask

  task automatic t_lof();
    for (int i = 0; i < 40; i++) send_frame(K_BADPAY, 7);
    pulse_lof();
    chk("R8", "idle held over lof", int'(idle), 1);
    chk("R8", "no chg over lof", int'(idle_chg), 0);
    for (int i = 0; i < 62; i++) send_frame(K_BADPAY, 7);
    chk("R8", "count cleared by lof", int'(idle), 1);
    send_frame(K_BADPAY, 7);
    chk("R5", "clear after lof + 63", int'(idle), 0);
  endtask

  task automatic t_lof_midframe();
    send_frame(K_BADC, 4);
    pulse_lof();
    for (int i = 0; i < 62; i++) send_frame(K_GOOD, 7);
    chk("R8", "idle before 63 after partial", int'(idle), 0);
    send_frame(K_GOOD, 7);
    chk("R8", "partial frame discarded", int'(idle), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_declare();
    t_clear_chain();
    t_restart();
    t_lof();
    t_lof_midframe();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R9 watchdog: got 0 expected 1 (run completion)");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule